// File: doc/BRIEF.md
# Touch Key Suppression Arbiter

This block sits between a capacitive touch detection engine and four key output pins. On every acquisition step the engine presents one raw detect flag per key, and the arbiter decides which of those keys are reported as touched. All keys form one shared suppression group. When suppression is enabled, at most one key is reported at a time. The key that is reported keeps that role until its own detect flag drops. When suppression is disabled, every detecting key is reported.

The suppression mode comes from a strap input. The block reads it once, on the first clock after reset has been released and synchronised, and ignores it after that. Each key drives an open-drain, active-low output. The output is modelled as a pull-down enable plus the resulting pin level. Output 2 also carries a single low marker pulse after reset. The delay and the width of that pulse are parameters counted in clock cycles.

Top module: `touch_sup_arb`

## Requirements
- R1: After reset, and before any acquisition step, every pull-down enable is 0 and every pin level is 1.
- R2: With suppression off, after an acquisition step the reported set equals the detect flags of that step. Bit k is key k, for any combination of keys.
- R3: With suppression on, no more than one key is reported at any time.
- R4: With suppression on, a reported key that is still detecting stays reported, even when other keys start detecting.
- R5: With suppression on and no key reported, a step picks the lowest-numbered detecting key.
- R6: With suppression on, a step in which the reported key no longer detects reports no key. The next step hands the report to a key that is still detecting.
- R7: The reported set changes only on a clock where `acq_step_i` is 1. Detect flags that change between steps have no effect.
- R8: The strap is captured once after reset (1 means suppression on). Later changes of the strap do not change the mode.
- R9: The pin level of each key is the inverse of its pull-down enable, so a reported key reads 0.
- R10: Exactly once after reset, the pull-down enable of key 2 is forced to 1 for MARK_WIDTH cycles. This starts about MARK_DELAY cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_strap_i | input | 1 | Mode strap, 1 means suppression on; read once after reset |
| acq_step_i | input | 1 | One-cycle strobe: the detect flags hold a new acquisition |
| key_det_i | input | N_KEYS | Raw detect flag per key |
| key_pd_en_o | output | N_KEYS | Pull-down enable per output, 1 means the pin is driven low |
| key_pin_o | output | N_KEYS | Resulting active-low pin level per key |

## Verification
Two things can fall into the same acquisition step: the current owner releasing and a different key starting to detect. The bench provokes this by dropping the owner's flag and raising another key's flag in one step. It then expects an empty report for that step and the lowest still-detecting key on the following step. The marker pulse on output 2 can also overlap a report of key 2. The bench keeps these apart: it first measures the pulse with no steps applied, and only then starts the key scenarios, so each expected value has a single cause.

// File: rtl/touch_sup_pkg.sv
package touch_sup_pkg;
  typedef enum logic [1:0] {
    MK_WAIT  = 2'd0,
    MK_PULSE = 2'd1,
    MK_DONE  = 2'd2
  } mark_state_e;
endpackage

// File: rtl/touch_sup_rst_sync.sv
module touch_sup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/touch_sup_strap.sv
module touch_sup_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic mode_o,
  output logic armed_o
);
  logic mode_q, mode_d;
  logic armed_q, armed_d;

  always_comb begin
    armed_d = 1'b1;
    mode_d  = armed_q ? mode_q : strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign mode_o  = mode_q;
  assign armed_o = armed_q;

  // R8: once captured, the mode never moves
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mode_q));
endmodule

// File: rtl/touch_sup_arbiter.sv
module touch_sup_arbiter #(
  parameter int N_KEYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic              sup_on_i,
  input  logic              step_i,
  input  logic [N_KEYS-1:0] det_i,
  output logic [N_KEYS-1:0] rep_o
);
  logic [N_KEYS-1:0] rep_q, rep_d;
  logic [N_KEYS-1:0] pick;
  logic              step_en;
  logic              owner_held;

  assign step_en    = step_i & armed_i;
  assign owner_held = |(rep_q & det_i);

  // lowest-numbered detecting key
  always_comb begin
    pick = '0;
    for (int k = N_KEYS - 1; k >= 0; k--) begin
      if (det_i[k]) begin
        pick    = '0;
        pick[k] = 1'b1;
      end
    end
  end

  always_comb begin
    rep_d = rep_q;
    if (step_en) begin
      if (!sup_on_i)         rep_d = det_i;
      else if (rep_q == '0)  rep_d = pick;
      else if (!owner_held)  rep_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else        rep_q <= rep_d;
  end

  assign rep_o = rep_q;

  // R3: single winner under suppression
  a_r3_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    sup_on_i |-> ($countones(rep_q) <= 1));

  // R7: nothing moves between acquisition steps
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(rep_q));

  // R4: a still-detecting owner is kept
  a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && sup_on_i && step_i && rep_q != '0 && (rep_q & det_i) != '0)
      |=> (rep_q == $past(rep_q)));

  // R6: a released owner leaves an empty report for one step
  a_r6_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && sup_on_i && step_i && rep_q != '0 && (rep_q & det_i) == '0)
      |=> (rep_q == '0));
endmodule

// File: rtl/touch_sup_marker.sv
module touch_sup_marker
  import touch_sup_pkg::*;
#(
  parameter int MARK_DELAY = 2000000,
  parameter int MARK_WIDTH = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse_o
);
  localparam int CNT_MAX = (MARK_DELAY > MARK_WIDTH) ? MARK_DELAY : MARK_WIDTH;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(MARK_DELAY - 1);
  localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(MARK_WIDTH - 1);

  mark_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      MK_WAIT: begin
        if (cnt_q == DLY_LAST) begin
          st_d  = MK_PULSE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      MK_PULSE: begin
        if (cnt_q == WID_LAST) begin
          st_d  = MK_DONE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = MK_DONE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MK_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = (st_q == MK_PULSE);

  // R10: once the pulse ends it never comes back
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (st_q == MK_DONE));
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MK_DONE) |=> !pulse_o);
endmodule

// File: rtl/touch_sup_arb.sv
module touch_sup_arb #(
  parameter int N_KEYS     = 4,
  parameter int MARK_KEY   = 2,
  parameter int MARK_DELAY = 2000000,
  parameter int MARK_WIDTH = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_strap_i,
  input  logic              acq_step_i,
  input  logic [N_KEYS-1:0] key_det_i,
  output logic [N_KEYS-1:0] key_pd_en_o,
  output logic [N_KEYS-1:0] key_pin_o
);
  logic              rst_sync_n;
  logic              sup_on;
  logic              armed;
  logic              mark_pulse;
  logic [N_KEYS-1:0] rep;

  touch_sup_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  touch_sup_strap u_strap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .strap_i (sup_strap_i),
    .mode_o  (sup_on),
    .armed_o (armed)
  );

  touch_sup_arbiter #(.N_KEYS(N_KEYS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .armed_i  (armed),
    .sup_on_i (sup_on),
    .step_i   (acq_step_i),
    .det_i    (key_det_i),
    .rep_o    (rep)
  );

  touch_sup_marker #(.MARK_DELAY(MARK_DELAY), .MARK_WIDTH(MARK_WIDTH)) u_mark (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pulse_o (mark_pulse)
  );

  for (genvar k = 0; k < N_KEYS; k++) begin : g_out
    if (k == MARK_KEY) begin : g_mark
      assign key_pd_en_o[k] = rep[k] | mark_pulse;
    end else begin : g_plain
      assign key_pd_en_o[k] = rep[k];
    end
    assign key_pin_o[k] = ~key_pd_en_o[k];
  end

  // R9: a driven pin reads low
  a_r9_pin_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (key_pd_en_o & key_pin_o) == '0);
endmodule

// File: tb/touch_sup_arb_test.sv
module touch_sup_arb_test;
  localparam int NK  = 4;
  localparam int DLY = 30;
  localparam int WID = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strap;
  logic          step;
  logic [NK-1:0] det;
  logic [NK-1:0] pd_en;
  logic [NK-1:0] pin;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct { logic [NK-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event  chk_ev;

  logic [NK-1:0] m_rep;
  logic          m_sup;

  touch_sup_arb #(.N_KEYS(NK), .MARK_KEY(2), .MARK_DELAY(DLY), .MARK_WIDTH(WID)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_strap_i (strap),
    .acq_step_i  (step),
    .key_det_i   (det),
    .key_pd_en_o (pd_en),
    .key_pin_o   (pin)
  );

  always #5 clk = ~clk;

  task automatic check(input logic [NK-1:0] act, input logic [NK-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at the ports
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(pd_en, it.exp, it.tag);
        check(pin, ~it.exp, {it.tag, "/R9"});
      end
    end
  end

  // bench reference for one acquisition step
  function automatic logic [NK-1:0] ref_step(input logic [NK-1:0] cur, input logic [NK-1:0] d,
                                             input logic sup);
    logic [NK-1:0] r;
    if (!sup) return d;
    if (cur != '0) return ((cur & d) != '0) ? cur : '0;
    r = '0;
    for (int k = 0; k < NK; k++) if (d[k] && r == '0) r[k] = 1'b1;
    return r;
  endfunction

  task automatic do_step(input logic [NK-1:0] d, input string tag);
    @(negedge clk);
    det  = d;
    step = 1'b1;
    @(negedge clk);
    step  = 1'b0;
    m_rep = ref_step(m_rep, d, m_sup);
    sb_q.push_back('{exp: m_rep, tag: tag});
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0;
    strap = s;
    step  = 1'b0;
    det   = '0;
    m_rep = '0;
    m_sup = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int first, width, cyc;
    // ---- suppression on ----
    do_reset(1'b1);
    #1;
    check(pd_en, '0, "R1 reset enables");
    check(pin, '1, "R1 reset pins");
    // R10: marker pulse measured with no steps applied
    first = -1; width = 0; cyc = 0;
    repeat (DLY + WID + 20) begin
      @(negedge clk);
      cyc++;
      if (pd_en[2]) begin
        if (first < 0) first = cyc;
        width++;
      end
    end
    check(4'(width), 4'(WID), "R10 pulse width");
    total++;
    if (first < DLY || first > DLY + 4) begin
      bad++;
      $display("FAIL R10 pulse start actual=%0d expected=%0d..%0d", first, DLY, DLY + 4);
    end
    check(pd_en & 4'b1011, '0, "R10 other outputs quiet");

    do_step(4'b0110, "R5 lowest of 1,2");
    do_step(4'b1111, "R4 owner kept");
    // R7: flags change with no step
    @(negedge clk); det = 4'b0001;
    repeat (3) @(negedge clk);
    check(pd_en, 4'b0010, "R7 hold between steps");
    do_step(4'b1101, "R6 owner released gap");
    do_step(4'b1100, "R6 handover next step");
    strap = 1'b0;
    do_step(4'b1100, "R8 strap change ignored (on)");
    do_step(4'b0000, "R3 all released");
    do_step(4'b1001, "R5 lowest of 0,3");
    do_step(4'b1011, "R3 single winner");

    // ---- suppression off ----
    do_reset(1'b0);
    repeat (DLY + WID + 20) @(negedge clk);
    do_step(4'b1011, "R2 pass 1011");
    do_step(4'b0110, "R2 pass 0110");
    do_step(4'b1111, "R2 pass all");
    strap = 1'b1;
    do_step(4'b1010, "R8 strap change ignored (off)");
    @(negedge clk); det = 4'b0000;
    repeat (2) @(negedge clk);
    check(pd_en, 4'b1010, "R7 hold between steps (off)");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule